// File: doc/BRIEF.md
# Indirect Redirection-Table Register Window

This block puts a full set of interrupt-routing registers behind two 32-bit bus locations: a selector and a data port. Software first writes the number of the internal register it wants into the selector. It then reads or writes that register through the data port. The internal space holds four kinds of register:

- an identifier register;
- a fixed version word;
- an arbitration word that always reads zero;
- a table of 64-bit redirection entries, each reached as two consecutive 32-bit halves.

The complete table is driven out in parallel to the delivery logic. A one-cycle strobe tells that logic to re-evaluate pending requests after any table update. The delivery logic also has its own port for clearing the remote-request flag of one entry. That port wins over a bus write to the same entry in the same cycle.

The bus is a single-cycle request port. Writes take effect at the clock edge that samples them. Read data comes back, with a valid flag, one cycle after the request.

Top module: `irw_top`

## Requirements
- R1: Only address bits [7:0] are decoded. Offset 0x00 is the selector and offset 0x10 is the data port. Every other offset reads 0 and ignores writes, whatever the upper address bits are.
- R2: The selector is 8 bits wide. A write keeps wdata[7:0]. A read returns that value zero-extended.
- R3: Index 0x00 is the identifier. A write keeps only wdata[27:24]. A read returns the stored value in bits [27:24], with all other bits 0.
- R4: Index 0x01 is read-only. It returns 0x11 in bits [7:0] and ENTRIES-1 in bits [23:16], which gives 0x00170011 for 24 entries. Writes are ignored.
- R5: Index 0x02 and every index that maps to no register read 0 and ignore writes. These are 0x03 to 0x0F, and everything from 0x10+2*ENTRIES upward.
- R6: Entry n has its bits [31:0] at index 0x10+2n and its bits [63:32] at index 0x11+2n. Writing one half leaves the other half unchanged. Entry n appears on tbl_entries[64n+63:64n].
- R7: tbl_wr_strobe is high for exactly the one cycle after a data-port write to an implemented table index. It stays low for every other write.
- R8: Reset clears the selector and the identifier. It sets every entry to 0x0000_0000_0001_0000, which is only the mask bit, bit 16.
- R9: bus_rvalid is high in the cycle after a read request and only then. bus_rdata carries the value the register held when the request was made.
- R10: A clear pulse with index n below ENTRIES clears bit 14 (the remote-request flag) of entry n and changes no other bit. When a bus write to the low half of entry n lands in the same cycle, the written data is kept except that bit 14 ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [7:0] are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after a read) |
| bus_rdata | output | 32 | Read data |
| tbl_entries | output | ENTRIES*64 | All table entries, entry n at [64n+63:64n] |
| tbl_wr_strobe | output | 1 | One-cycle pulse after any table write |
| eoi_clr_valid | input | 1 | Clear remote-request flag request |
| eoi_clr_index | input | $clog2(ENTRIES) | Entry whose flag is cleared |

## Verification
The bound checker watches the following on every cycle:
- read latency;
- the origin of each strobe pulse;
- the constant version word;
- the zero bits around the identifier field;
- the arbitration word;
- the cleared flag after a clear pulse;
- the rule that the table stays still when neither a bus write nor a clear occurred.

Other properties need the bench's targeted sequences, because each depends on a history of several accesses:
- half-entry isolation;
- aliasing through the upper address bits;
- the ignored writes to unmapped indices;
- the reset contents;
- the same-cycle collision between a clear and a bus write.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned ENTRY_W    = 64;
    localparam int unsigned SEL_W      = 8;

    // Bus offsets (low address byte)
    localparam logic [7:0] OFS_SELECT  = 8'h00;
    localparam logic [7:0] OFS_WINDOW  = 8'h10;

    // Internal indices
    localparam logic [SEL_W-1:0] IDX_IDENT   = 8'h00;
    localparam logic [SEL_W-1:0] IDX_VERSION = 8'h01;
    localparam logic [SEL_W-1:0] IDX_ARBIT   = 8'h02;
    localparam logic [SEL_W-1:0] IDX_TABLE   = 8'h10;

    localparam logic [7:0]  VERSION_CODE = 8'h11;
    localparam int unsigned IDENT_LSB    = 24;
    localparam int unsigned IDENT_W      = 4;
    localparam int unsigned MAXENT_LSB   = 16;
    localparam int unsigned MASK_BIT     = 16;
    localparam int unsigned RIRR_BIT     = 14;

    typedef logic [ENTRY_W-1:0] entry_t;

    localparam entry_t ENTRY_RESET = entry_t'(64'd1 << MASK_BIT);

    typedef enum logic [1:0] {
        PORT_NONE,
        PORT_SELECT,
        PORT_WINDOW
    } port_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_IDENT,
        TGT_VERSION,
        TGT_ARBIT,
        TGT_TABLE
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic             upper;
        logic [SEL_W-1:0] slot;
    } win_t;

    function automatic port_e decode_port(input logic [7:0] ofs);
        if (ofs == OFS_SELECT) begin
            return PORT_SELECT;
        end else if (ofs == OFS_WINDOW) begin
            return PORT_WINDOW;
        end
        return PORT_NONE;
    endfunction

    function automatic win_t decode_window(input logic [SEL_W-1:0] sel,
                                           input int unsigned entries);
        win_t w;
        w.tgt   = TGT_NONE;
        w.upper = sel[0];
        w.slot  = '0;
        if (sel == IDX_IDENT) begin
            w.tgt = TGT_IDENT;
        end else if (sel == IDX_VERSION) begin
            w.tgt = TGT_VERSION;
        end else if (sel == IDX_ARBIT) begin
            w.tgt = TGT_ARBIT;
        end else if ((sel >= IDX_TABLE) &&
                     (32'(sel) < 32'(IDX_TABLE) + 2 * entries)) begin
            w.tgt  = TGT_TABLE;
            w.slot = (sel - IDX_TABLE) >> 1;
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] version_word(input int unsigned entries);
        return 32'(VERSION_CODE) | (32'(entries - 1) << MAXENT_LSB);
    endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int unsigned ENTRIES = 24
) (
    input  logic [7:0]       ofs,
    input  logic [SEL_W-1:0] sel,
    output port_e            port,
    output win_t             win
);

    always_comb begin
        port = decode_port(ofs);
        win  = decode_window(sel, ENTRIES);
    end

endmodule

// File: rtl/irw_table.sv
module irw_table
    import irw_pkg::*;
#(
    parameter int unsigned ENTRIES = 24,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_slot,
    input  logic                       wr_upper,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       clr_en,
    input  logic [IDX_W-1:0]           clr_slot,
    output logic [ENTRIES*ENTRY_W-1:0] entries
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        entry_t ent_q;
        logic   hit_wr;
        logic   hit_clr;

        assign hit_wr  = wr_en  && (wr_slot  == SEL_W'(e));
        assign hit_clr = clr_en && (clr_slot == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= ENTRY_RESET;
            end else begin
                if (hit_wr) begin
                    if (wr_upper) begin
                        ent_q[ENTRY_W-1:WORD_W] <= wr_data;
                    end else begin
                        ent_q[WORD_W-1:0] <= wr_data;
                    end
                end
                // delivery-side clear overrides a same-cycle bus write
                if (hit_clr) begin
                    ent_q[RIRR_BIT] <= 1'b0;
                end
            end
        end

        assign entries[e*ENTRY_W +: ENTRY_W] = ent_q;
    end

endmodule

// File: rtl/irw_rdmux.sv
module irw_rdmux
    import irw_pkg::*;
#(
    parameter int unsigned ENTRIES = 24
) (
    input  port_e                      port,
    input  win_t                       win,
    input  logic [SEL_W-1:0]           sel_q,
    input  logic [IDENT_W-1:0]         ident_q,
    input  logic [ENTRIES*ENTRY_W-1:0] entries,
    output logic [WORD_W-1:0]          rdata
);

    logic [WORD_W-1:0] tbl_word;

    always_comb begin
        tbl_word = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (win.slot == SEL_W'(e)) begin
                tbl_word = win.upper ? entries[e*ENTRY_W + WORD_W +: WORD_W]
                                     : entries[e*ENTRY_W +: WORD_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (port)
            PORT_SELECT: rdata = WORD_W'(sel_q);
            PORT_WINDOW: begin
                case (win.tgt)
                    TGT_IDENT:   rdata = WORD_W'(ident_q) << IDENT_LSB;
                    TGT_VERSION: rdata = version_word(ENTRIES);
                    TGT_TABLE:   rdata = tbl_word;
                    default:     rdata = '0;
                endcase
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/irw_top.sv
module irw_top
    import irw_pkg::*;
#(
    parameter int unsigned ENTRIES = 24,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_req,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic                       bus_rvalid,
    output logic [31:0]                bus_rdata,
    output logic [ENTRIES*64-1:0]      tbl_entries,
    output logic                       tbl_wr_strobe,
    input  logic                       eoi_clr_valid,
    input  logic [IDX_W-1:0]           eoi_clr_index
);

    logic [SEL_W-1:0]   sel_q;
    logic [IDENT_W-1:0] ident_q;
    logic               rvalid_q;
    logic [WORD_W-1:0]  rdata_q;
    logic               strobe_q;

    port_e              port;
    win_t               win;
    logic [WORD_W-1:0]  rdata_next;
    logic               addr_hi_unused;

    logic               do_rd;
    logic               do_wr_sel;
    logic               do_wr_win;
    logic               do_wr_ident;
    logic               do_wr_tbl;

    assign addr_hi_unused = ^bus_addr[ADDR_W-1:8];

    irw_decode #(.ENTRIES(ENTRIES)) u_decode (
        .ofs  (bus_addr[7:0]),
        .sel  (sel_q),
        .port (port),
        .win  (win)
    );

    assign do_rd       = bus_req && !bus_we;
    assign do_wr_sel   = bus_req && bus_we && (port == PORT_SELECT);
    assign do_wr_win   = bus_req && bus_we && (port == PORT_WINDOW);
    assign do_wr_ident = do_wr_win && (win.tgt == TGT_IDENT);
    assign do_wr_tbl   = do_wr_win && (win.tgt == TGT_TABLE);

    irw_table #(.ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (do_wr_tbl),
        .wr_slot  (win.slot),
        .wr_upper (win.upper),
        .wr_data  (bus_wdata),
        .clr_en   (eoi_clr_valid),
        .clr_slot (eoi_clr_index),
        .entries  (tbl_entries)
    );

    irw_rdmux #(.ENTRIES(ENTRIES)) u_rdmux (
        .port    (port),
        .win     (win),
        .sel_q   (sel_q),
        .ident_q (ident_q),
        .entries (tbl_entries),
        .rdata   (rdata_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            ident_q  <= '0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            strobe_q <= 1'b0;
        end else begin
            rvalid_q <= do_rd;
            rdata_q  <= do_rd ? rdata_next : '0;
            strobe_q <= do_wr_tbl;
            if (do_wr_sel) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
            if (do_wr_ident) begin
                ident_q <= bus_wdata[IDENT_LSB +: IDENT_W];
            end
        end
    end

    assign bus_rvalid    = rvalid_q;
    assign bus_rdata     = rdata_q;
    assign tbl_wr_strobe = strobe_q;

endmodule

// File: rtl/irw_checker.sv
module irw_checker
    import irw_pkg::*;
#(
    parameter int unsigned ENTRIES = 24,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int unsigned TBL_END = 32'(IDX_TABLE) + 2 * ENTRIES
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_req,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_rvalid,
    input logic [31:0]           bus_rdata,
    input logic [ENTRIES*64-1:0] tbl_entries,
    input logic                  tbl_wr_strobe,
    input logic                  eoi_clr_valid,
    input logic [IDX_W-1:0]      eoi_clr_index,
    input logic [SEL_W-1:0]      sel_q
);

    logic             seen_q;
    logic             clr_v_q;
    logic [IDX_W-1:0] clr_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q    <= 1'b0;
            clr_v_q   <= 1'b0;
            clr_idx_q <= '0;
        end else begin
            seen_q    <= 1'b1;
            clr_v_q   <= eoi_clr_valid &&
                         ({1'b0, eoi_clr_index} < (IDX_W+1)'(ENTRIES));
            clr_idx_q <= eoi_clr_index;
        end
    end

    assert_rd_latency_R9: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (bus_rvalid == $past(bus_req && !bus_we)));

    assert_strobe_origin_R7: assert property (@(posedge clk) disable iff (rst)
        (seen_q && tbl_wr_strobe) |->
            $past(bus_req && bus_we && (bus_addr[7:0] == OFS_WINDOW) &&
                  (sel_q >= IDX_TABLE) && (32'(sel_q) < TBL_END)));

    assert_version_const_R4: assert property (@(posedge clk) disable iff (rst)
        (seen_q && bus_rvalid &&
         $past((bus_addr[7:0] == OFS_WINDOW) && (sel_q == IDX_VERSION))) |->
            (bus_rdata == version_word(ENTRIES)));

    assert_ident_field_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_q && bus_rvalid &&
         $past((bus_addr[7:0] == OFS_WINDOW) && (sel_q == IDX_IDENT))) |->
            ((bus_rdata & ~32'h0F00_0000) == 32'h0));

    assert_arbit_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (seen_q && bus_rvalid &&
         $past((bus_addr[7:0] == OFS_WINDOW) && (sel_q == IDX_ARBIT))) |->
            (bus_rdata == 32'h0));

    assert_clear_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (seen_q && clr_v_q) |-> (tbl_entries[{clr_idx_q, 6'd14}] == 1'b0));

    assert_table_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(bus_req && bus_we) && !$past(eoi_clr_valid)) |->
            $stable(tbl_entries));

endmodule

bind irw_top irw_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_irw_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_rvalid    (bus_rvalid),
    .bus_rdata     (bus_rdata),
    .tbl_entries   (tbl_entries),
    .tbl_wr_strobe (tbl_wr_strobe),
    .eoi_clr_valid (eoi_clr_valid),
    .eoi_clr_index (eoi_clr_index),
    .sel_q         (sel_q)
);

// File: tb/tb_irw_top.sv
module tb_irw_top;

    localparam int unsigned ENTRIES = 24;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned IDX_W   = $clog2(ENTRIES);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  bus_req = 1'b0;
    logic                  bus_we = 1'b0;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic [31:0]           bus_wdata = '0;
    logic                  bus_rvalid;
    logic [31:0]           bus_rdata;
    logic [ENTRIES*64-1:0] tbl_entries;
    logic                  tbl_wr_strobe;
    logic                  eoi_clr_valid = 1'b0;
    logic [IDX_W-1:0]      eoi_clr_index = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    irw_top #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) dut (
        .clk           (clk),
        .rst           (rst),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rvalid    (bus_rvalid),
        .bus_rdata     (bus_rdata),
        .tbl_entries   (tbl_entries),
        .tbl_wr_strobe (tbl_wr_strobe),
        .eoi_clr_valid (eoi_clr_valid),
        .eoi_clr_index (eoi_clr_index)
    );

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pops scoreboard entries as read data returns
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R9 unexpected rvalid actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(64'(bus_rdata), 64'(e), t);
            end
        end
    end

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic exp_stb, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        check(64'(tbl_wr_strobe), 64'(exp_stb), {tag, " strobe"});
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                            input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic select(input logic [7:0] idx);
        bus_write(12'h000, {24'h0, idx}, 1'b0, "R2 select");
    endtask

    function automatic logic [63:0] ent(input int n);
        return tbl_entries[n*64 +: 64];
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [ENTRIES*64-1:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        for (int e = 0; e < ENTRIES; e++) begin
            check(ent(e), 64'h0000_0000_0001_0000, "R8 entry reset");
        end
        check(64'(bus_rvalid), 64'h0, "R9 idle rvalid");
        bus_read(12'h000, 32'h0, "R8 selector reset");
        select(8'h00);
        bus_read(12'h010, 32'h0, "R8 identifier reset");

        // R2: selector keeps low byte
        bus_write(12'h000, 32'hABCD_1234, 1'b0, "R2 write");
        bus_read(12'h000, 32'h0000_0034, "R2 readback");

        // R3: identifier keeps bits [27:24]
        select(8'h00);
        bus_write(12'h010, 32'hFFFF_FFFF, 1'b0, "R3 write");
        bus_read(12'h010, 32'h0F00_0000, "R3 readback");
        bus_write(12'h010, 32'h05FF_0000, 1'b0, "R3 write2");
        bus_read(12'h010, 32'h0500_0000, "R3 readback2");

        // R4: version read-only
        select(8'h01);
        bus_read(12'h010, 32'h0017_0011, "R4 version");
        bus_write(12'h010, 32'hFFFF_FFFF, 1'b0, "R4 write");
        bus_read(12'h010, 32'h0017_0011, "R4 version after write");

        // R5: arbitration and unmapped indices
        snap = tbl_entries;
        select(8'h02);
        bus_write(12'h010, 32'hFFFF_FFFF, 1'b0, "R5 arbit write");
        bus_read(12'h010, 32'h0, "R5 arbit read");
        select(8'h07);
        bus_write(12'h010, 32'hFFFF_FFFF, 1'b0, "R5 idx07 write");
        bus_read(12'h010, 32'h0, "R5 idx07 read");
        select(8'h40);
        bus_write(12'h010, 32'hDEAD_BEEF, 1'b0, "R5 idx40 write");
        bus_read(12'h010, 32'h0, "R5 idx40 read");
        check(64'(tbl_entries == snap), 64'h1, "R5 table untouched");

        // R6/R7: table halves
        select(8'h10);
        bus_write(12'h010, 32'h1234_5678, 1'b1, "R7 low write");
        @(negedge clk);
        check(64'(tbl_wr_strobe), 64'h0, "R7 strobe one cycle");
        bus_read(12'h010, 32'h1234_5678, "R6 low readback");
        select(8'h11);
        bus_write(12'h010, 32'hAB00_0000, 1'b1, "R7 high write");
        bus_read(12'h010, 32'hAB00_0000, "R6 high readback");
        check(ent(0), 64'hAB00_0000_1234_5678, "R6 entry0 port");
        check(ent(1), 64'h0000_0000_0001_0000, "R6 entry1 untouched");
        select(8'h3F);
        bus_write(12'h010, 32'hCAFE_0001, 1'b1, "R7 last high write");
        select(8'h3E);
        bus_read(12'h010, 32'h0001_0000, "R6 last low kept");
        check(ent(23), 64'hCAFE_0001_0001_0000, "R6 entry23 port");

        // R1: upper address bits ignored, other offsets dead
        select(8'h10);
        bus_read(12'h110, 32'h1234_5678, "R1 alias window");
        bus_read(12'h008, 32'h0, "R1 offset08 read");
        snap = tbl_entries;
        bus_write(12'h020, 32'h0000_0055, 1'b0, "R1 offset20 write");
        bus_read(12'h000, 32'h0000_0010, "R1 select unchanged");
        bus_read(12'hF00, 32'h0000_0010, "R1 alias select");
        check(64'(tbl_entries == snap), 64'h1, "R1 table untouched");

        // R10: remote flag clear
        select(8'h16);
        bus_write(12'h010, 32'h0000_4033, 1'b1, "R10 set flag");
        check(ent(3), 64'h0000_0000_0000_4033, "R10 flag set");
        @(negedge clk);
        eoi_clr_valid = 1'b1; eoi_clr_index = 5'd3;
        @(negedge clk);
        eoi_clr_valid = 1'b0;
        check(ent(3), 64'h0000_0000_0000_0033, "R10 flag cleared");
        check(ent(0), 64'hAB00_0000_1234_5678, "R10 other entry kept");

        select(8'h1A);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h0000_4055;
        eoi_clr_valid = 1'b1; eoi_clr_index = 5'd5;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; eoi_clr_valid = 1'b0;
        check(64'(tbl_wr_strobe), 64'h1, "R7 strobe on collision");
        check(ent(5), 64'h0000_0000_0000_0055, "R10 clear beats write");

        repeat (3) @(negedge clk);
        check(64'(exp_q.size()), 64'h0, "R9 all reads returned");
        done = 1'b1;
        finish_run();
    end

endmodule